// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block looks up a page-table entry in a hashed table that lives in ordinary memory. The caller supplies a 24-bit segment identifier, the 28-bit offset of the access inside its segment, the kind of access, the protection key and no-execute flag that apply to the segment, and the table's base address and size mask. The walker derives a hash from the identifier and the page index. It reads candidate entries one 32-bit word at a time through a request/acknowledge memory port, first in the primary group and then in the secondary group, and stops at the first matching entry.

On a hit it returns the entry's offset and both of its words, the real address, the access rights that result from the entry's protection field, and whether the access is allowed. On an allowed access it sets the referenced bit, and for stores the changed bit, directly in memory, each with a single byte write. A load or fetch that finds the changed bit clear loses write permission in the returned rights instead. Segment lookup, block translation and fault encoding belong to the surrounding logic.

Top module: `hash_pte_walker`

## Requirements
- R1: The primary group offset is ((vsid XOR page index) * 64) AND tbl_mask, where the page index is seg_off[27:12]. Entry n of a group sits at group offset + 8*n, and its first word is at +0 and its second word at +4. Memory addresses are tbl_base + offset, and tbl_base is 64-byte aligned.
- R2: An entry matches only when first-word bit 31 (valid) is 1, bits 30:7 equal vsid, bit 6 (hash select) equals the current secondary flag, and bits 5:0 equal seg_off[27:22].
- R3: The eight primary slots are searched in ascending order with the flag at 0. The group at the bitwise complement of the 24-bit hash is searched with the flag at 1, and only after all primary slots have missed.
- R4: A second word is read only after the first word of the same entry has matched. Non-matching entries cost one word read each, and a hit costs one further read.
- R5: When 16 entries fail to match, the walk ends with hit=0 and granted=0 after exactly 16 word reads and no writes.
- R6: Rights are {exec, write, read} in bits 2:0, with pp = second-word bits 1:0. With key 0, pp 3 gives read and any other pp gives read+write. With key 1, pp 0 gives nothing, pp 2 gives read+write, and pp 1 or 3 gives read. Exec is added when no_exec is 0.
- R7: Access code 0 is a load and needs read, 1 is a store and needs write, and 2 is a fetch and needs exec. granted is 1 only on a hit whose rights contain the needed bit.
- R8: On a granted hit whose second-word bit 8 (referenced) is 0, one byte is written at entry + 6 with value (word1[15:8] | 0x01). Memory is big-endian, so this lands in bits 15:8 of the second word. No byte is written on a denied access.
- R9: On a granted hit whose second-word bit 7 (changed) is 0, a store writes one byte at entry + 7 with value (word1[7:0] | 0x80). A load or fetch writes nothing for this bit and has write removed from the returned rights.
- R10: On a hit, real_addr = {word1[31:12], seg_off[11:0]}, entry_off is the entry's table offset without the base, and entry_w0/entry_w1 are the words as read.
- R11: A memory request keeps its address, direction and byte value unchanged until mem_ack, and each request completes on the cycle mem_ack is high.
- R12: After reset the block is idle with no request and all results 0. done is high for one cycle per walk, and the results stay unchanged from done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| vsid | input | 24 | Virtual segment identifier |
| seg_off | input | 28 | Access offset within the segment |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| prot_key | input | 1 | Protection key for this access |
| no_exec | input | 1 | Segment forbids execution |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 32 | Table offset mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Entry found |
| granted | output | 1 | Access allowed |
| entry_off | output | 32 | Offset of the found entry |
| entry_w0 | output | 32 | First word of the entry |
| entry_w1 | output | 32 | Second word of the entry |
| prot | output | 3 | Resulting rights {exec, write, read} |
| real_addr | output | 32 | Translated address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for byte write, 0 for word read |
| mem_addr | output | 32 | Byte address |
| mem_wbyte | output | 8 | Byte to write |
| mem_ack | input | 1 | Request complete |
| mem_rdata | input | 32 | Read word, valid with mem_ack |

## Verification
Several properties hold on every cycle and are checked by assertions: a request is held stable until it is acknowledged, a second word is never fetched before its first word has matched, status bytes are written only for granted accesses and always carry the bit they set, the changed-bit byte appears only for stores, done lasts exactly one cycle, and no walk reads more than sixteen first words. The scenarios alone show that the right slot in the right group is found behind decoys (invalid entries and wrong hash-select bits), that the permission table and the changed-bit write removal give the expected rights, that the real address and entry offset are right for a non-zero base and a narrow mask, and that the memory image holds exactly the expected bits afterwards.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int VSID_W    = 24;
  localparam int AW        = 32;
  localparam int DW        = 32;
  localparam int PGIDX_W   = 16;
  localparam int PGOFF_W   = 12;
  localparam int SEG_OFF_W = PGIDX_W + PGOFF_W;
  localparam int API_W     = 6;
  localparam int PROT_W    = 3;

  localparam int PROT_RD = 0;
  localparam int PROT_WR = 1;
  localparam int PROT_EX = 2;

  // first word layout
  localparam int W0_VALID    = 31;
  localparam int W0_VSID_LSB = 7;
  localparam int W0_HSEL     = 6;
  // second word layout
  localparam int W1_REF     = 8;
  localparam int W1_CHG     = 7;
  localparam int W1_RPN_LSB = 12;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_EVAL, ST_WR_R, ST_WR_C, ST_FIN
  } walk_st_e;

  function automatic logic [VSID_W-1:0] pg_hash(input logic [VSID_W-1:0] id,
                                                input logic [PGIDX_W-1:0] pg);
    return id ^ VSID_W'(pg);
  endfunction

  function automatic logic [API_W-1:0] api_of(input logic [PGIDX_W-1:0] pg);
    return pg[PGIDX_W-1 -: API_W];
  endfunction

  function automatic logic [PROT_W-1:0] pp_rights(input logic key,
                                                  input logic [1:0] pp,
                                                  input logic nx);
    logic [PROT_W-1:0] r;
    r = '0;
    if (!key) begin
      r[PROT_RD] = 1'b1;
      r[PROT_WR] = (pp != 2'b11);
    end else begin
      case (pp)
        2'b00:   r = '0;
        2'b10:   begin r[PROT_RD] = 1'b1; r[PROT_WR] = 1'b1; end
        default: r[PROT_RD] = 1'b1;
      endcase
    end
    if (!nx) r[PROT_EX] = 1'b1;
    return r;
  endfunction

  function automatic logic [PROT_W-1:0] need_mask(input logic [1:0] acc);
    logic [PROT_W-1:0] m;
    m = '0;
    case (acc)
      ACC_LOAD:  m[PROT_RD] = 1'b1;
      ACC_STORE: m[PROT_WR] = 1'b1;
      ACC_FETCH: m[PROT_EX] = 1'b1;
      default:   m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/hpw_addr_gen.sv
module hpw_addr_gen
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 8,
  localparam int SLOT_W       = $clog2(GROUP_ENTRIES)
) (
  input  logic [VSID_W-1:0]  vsid,
  input  logic [PGIDX_W-1:0] pgidx,
  input  logic               secondary,
  input  logic [AW-1:0]      tbl_mask,
  input  logic [SLOT_W-1:0]  slot,
  output logic [AW-1:0]      entry_off
);
  localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);

  logic [VSID_W-1:0] hash_pri;
  logic [VSID_W-1:0] hash_sel;
  logic [AW-1:0]     group_off;

  always_comb begin
    hash_pri  = pg_hash(vsid, pgidx);
    hash_sel  = secondary ? ~hash_pri : hash_pri;
    group_off = (AW'(hash_sel) << GROUP_SHIFT) & tbl_mask;
    entry_off = group_off + AW'(slot) * AW'(ENTRY_BYTES);
  end
endmodule

// File: rtl/hpw_entry_match.sv
module hpw_entry_match
  import hpw_pkg::*;
(
  input  logic [DW-1:0]      word0,
  input  logic [VSID_W-1:0]  vsid,
  input  logic [PGIDX_W-1:0] pgidx,
  input  logic               secondary,
  output logic               match
);
  logic valid_ok, hsel_ok, id_ok, api_ok;

  always_comb begin
    valid_ok = word0[W0_VALID];
    hsel_ok  = (word0[W0_HSEL] == secondary);
    id_ok    = (word0[W0_VSID_LSB +: VSID_W] == vsid);
    api_ok   = (word0[API_W-1:0] == api_of(pgidx));
    match    = valid_ok && hsel_ok && id_ok && api_ok;
  end
endmodule

// File: rtl/hpw_perm.sv
module hpw_perm
  import hpw_pkg::*;
(
  input  logic [1:0]        pp,
  input  logic              key,
  input  logic              nx,
  input  logic              ref_bit,
  input  logic              chg_bit,
  input  logic [1:0]        acc,
  output logic [PROT_W-1:0] rights,
  output logic              granted,
  output logic              set_ref,
  output logic              set_chg
);
  logic [PROT_W-1:0] raw;
  logic [PROT_W-1:0] need;
  logic              is_store;

  always_comb begin
    raw      = pp_rights(key, pp, nx);
    need     = need_mask(acc);
    is_store = (acc == ACC_STORE);
    granted  = |(raw & need);
    rights   = raw;
    if (granted && !chg_bit && !is_store) rights[PROT_WR] = 1'b0;
    set_ref  = granted && !ref_bit;
    set_chg  = granted && !chg_bit && is_store;
  end
endmodule

// File: rtl/hash_pte_walker.sv
module hash_pte_walker
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [VSID_W-1:0]    vsid,
  input  logic [SEG_OFF_W-1:0] seg_off,
  input  logic [1:0]           acc_kind,
  input  logic                 prot_key,
  input  logic                 no_exec,
  input  logic [AW-1:0]        tbl_base,
  input  logic [AW-1:0]        tbl_mask,
  output logic                 busy,
  output logic                 done,
  output logic                 hit,
  output logic                 granted,
  output logic [AW-1:0]        entry_off,
  output logic [DW-1:0]        entry_w0,
  output logic [DW-1:0]        entry_w1,
  output logic [PROT_W-1:0]    prot,
  output logic [AW-1:0]        real_addr,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_wbyte,
  input  logic                 mem_ack,
  input  logic [DW-1:0]        mem_rdata
);
  localparam int SLOT_W    = $clog2(GROUP_ENTRIES);
  localparam int W1_BYTE   = DW / 8;
  localparam int REF_BYTE  = W1_BYTE + 2;
  localparam int CHG_BYTE  = W1_BYTE + 3;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

  walk_st_e state;

  // latched request
  logic [VSID_W-1:0]  vsid_q;
  logic [PGIDX_W-1:0] pgidx_q;
  logic [PGOFF_W-1:0] pgoff_q;
  logic [1:0]         acc_q;
  logic               key_q;
  logic               nx_q;
  logic [AW-1:0]      base_q;
  logic [AW-1:0]      mask_q;

  // walk state
  logic [SLOT_W-1:0]  slot_q;
  logic               sec_q;
  logic [AW-1:0]      ent_off_q;
  logic [DW-1:0]      w0_q;
  logic [DW-1:0]      w1_q;
  logic               hit_q;
  logic               granted_q;
  logic [PROT_W-1:0]  prot_q;

  // internal events brought out for the checker
  logic               w0_matched;
  logic               grant_ok;

  logic [AW-1:0]      cur_off;
  logic               ent_match;
  logic [PROT_W-1:0]  perm_rights;
  logic               perm_grant;
  logic               perm_set_ref;
  logic               perm_set_chg;

  hpw_addr_gen #(
    .GROUP_ENTRIES(GROUP_ENTRIES),
    .ENTRY_BYTES  (ENTRY_BYTES)
  ) u_addr_gen (
    .vsid     (vsid_q),
    .pgidx    (pgidx_q),
    .secondary(sec_q),
    .tbl_mask (mask_q),
    .slot     (slot_q),
    .entry_off(cur_off)
  );

  hpw_entry_match u_entry_match (
    .word0    (mem_rdata),
    .vsid     (vsid_q),
    .pgidx    (pgidx_q),
    .secondary(sec_q),
    .match    (ent_match)
  );

  hpw_perm u_perm (
    .pp     (w1_q[1:0]),
    .key    (key_q),
    .nx     (nx_q),
    .ref_bit(w1_q[W1_REF]),
    .chg_bit(w1_q[W1_CHG]),
    .acc    (acc_q),
    .rights (perm_rights),
    .granted(perm_grant),
    .set_ref(perm_set_ref),
    .set_chg(perm_set_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      vsid_q     <= '0;
      pgidx_q    <= '0;
      pgoff_q    <= '0;
      acc_q      <= '0;
      key_q      <= 1'b0;
      nx_q       <= 1'b0;
      base_q     <= '0;
      mask_q     <= '0;
      slot_q     <= '0;
      sec_q      <= 1'b0;
      ent_off_q  <= '0;
      w0_q       <= '0;
      w1_q       <= '0;
      hit_q      <= 1'b0;
      granted_q  <= 1'b0;
      prot_q     <= '0;
      w0_matched <= 1'b0;
      grant_ok   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            vsid_q     <= vsid;
            pgidx_q    <= seg_off[SEG_OFF_W-1:PGOFF_W];
            pgoff_q    <= seg_off[PGOFF_W-1:0];
            acc_q      <= acc_kind;
            key_q      <= prot_key;
            nx_q       <= no_exec;
            base_q     <= tbl_base;
            mask_q     <= tbl_mask;
            slot_q     <= '0;
            sec_q      <= 1'b0;
            w0_matched <= 1'b0;
            grant_ok   <= 1'b0;
            state      <= ST_RD0;
          end
        end
        ST_RD0: begin
          if (mem_ack) begin
            w0_q <= mem_rdata;
            if (ent_match) begin
              w0_matched <= 1'b1;
              ent_off_q  <= cur_off;
              state      <= ST_RD1;
            end else if (slot_q == LAST_SLOT) begin
              if (!sec_q) begin
                sec_q  <= 1'b1;
                slot_q <= '0;
              end else begin
                hit_q     <= 1'b0;
                granted_q <= 1'b0;
                prot_q    <= '0;
                state     <= ST_FIN;
              end
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        ST_RD1: begin
          if (mem_ack) begin
            w1_q  <= mem_rdata;
            state <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          hit_q     <= 1'b1;
          granted_q <= perm_grant;
          prot_q    <= perm_rights;
          grant_ok  <= perm_grant;
          if (perm_set_ref)      state <= ST_WR_R;
          else if (perm_set_chg) state <= ST_WR_C;
          else                   state <= ST_FIN;
        end
        ST_WR_R: begin
          if (mem_ack) state <= perm_set_chg ? ST_WR_C : ST_FIN;
        end
        ST_WR_C: begin
          if (mem_ack) state <= ST_FIN;
        end
        ST_FIN: begin
          grant_ok <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // memory request decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wbyte = '0;
    case (state)
      ST_RD0: begin
        mem_req  = 1'b1;
        mem_addr = base_q + cur_off;
      end
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = base_q + ent_off_q + AW'(W1_BYTE);
      end
      ST_WR_R: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ent_off_q + AW'(REF_BYTE);
        mem_wbyte = w1_q[15:8] | 8'h01;
      end
      ST_WR_C: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ent_off_q + AW'(CHG_BYTE);
        mem_wbyte = w1_q[7:0] | 8'h80;
      end
      default: ;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign hit       = hit_q;
  assign granted   = granted_q;
  assign entry_off = ent_off_q;
  assign entry_w0  = w0_q;
  assign entry_w1  = w1_q;
  assign prot      = prot_q;
  assign real_addr = {w1_q[DW-1:W1_RPN_LSB], pgoff_q};
endmodule

// File: rtl/hpw_checker.sv
module hpw_checker
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          hit,
  input logic          granted,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wbyte,
  input logic          mem_ack,
  input logic [1:0]    acc_q,
  input logic          w0_matched,
  input logic          grant_ok
);
  localparam int MAX_READS = 2 * GROUP_ENTRIES;
  localparam int CNT_W     = $clog2(MAX_READS + 1) + 1;

  logic [CNT_W-1:0] first_reads;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_reads <= '0;
    else if (start && !busy) first_reads <= '0;
    else if (mem_req && !mem_we && mem_ack && !mem_addr[2])
      first_reads <= first_reads + 1'b1;
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wbyte)));

  assert_second_after_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_addr[2]) |-> w0_matched);

  assert_write_only_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> grant_ok);

  assert_ref_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[2:0] == 3'd6) |-> mem_wbyte[0]);

  assert_chg_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[2:0] == 3'd7) |-> (mem_wbyte[7] && acc_q == ACC_STORE));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_miss_denied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> !granted);

  assert_read_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    first_reads <= CNT_W'(MAX_READS));
endmodule

bind hash_pte_walker hpw_checker #(
  .GROUP_ENTRIES(GROUP_ENTRIES)
) u_hpw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .hit       (hit),
  .granted   (granted),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wbyte (mem_wbyte),
  .mem_ack   (mem_ack),
  .acc_q     (acc_q),
  .w0_matched(w0_matched),
  .grant_ok  (grant_ok)
);

// File: tb/hash_pte_walker_bench.sv
`timescale 1ns/1ps
module hash_pte_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic [27:0] seg_off = '0;
  logic [1:0]  acc_kind = '0;
  logic        prot_key = 1'b0;
  logic        no_exec = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_mask = '0;
  logic        busy, done, hit, granted;
  logic [31:0] entry_off, entry_w0, entry_w1, real_addr;
  logic [2:0]  prot;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wbyte;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  hash_pte_walker u_hash_pte_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .seg_off(seg_off),
    .acc_kind(acc_kind), .prot_key(prot_key), .no_exec(no_exec),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(busy), .done(done),
    .hit(hit), .granted(granted), .entry_off(entry_off), .entry_w0(entry_w0),
    .entry_w1(entry_w1), .prot(prot), .real_addr(real_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wbyte(mem_wbyte), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: 16 KiB, big-endian bytes, ack one cycle after request
  logic [31:0] mem [0:4095];
  int rd_cnt = 0;
  int wr_cnt = 0;

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[13:2]][(3 - mem_addr[1:0]) * 8 +: 8] <= mem_wbyte;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] vsid;
    logic [27:0] ea;
    logic [1:0]  acc;
    logic        key;
    logic        nx;
    logic [1:0]  place;  // 0 none, 1 primary, 2 secondary
    logic [2:0]  slot;
    logic [31:0] w1;
    logic [31:0] base;
    logic [31:0] mask;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{24'h000123, 28'h0456789, 2'd0, 1'b0, 1'b0, 2'd1, 3'd0, 32'h12345002, 32'h0, 32'h3FC0},
    '{24'h0A0B0C, 28'h3FFF123, 2'd1, 1'b1, 1'b0, 2'd1, 3'd7, 32'hABCDE102, 32'h0, 32'h3FC0},
    '{24'h111111, 28'h0ABC000, 2'd1, 1'b1, 1'b0, 2'd1, 3'd3, 32'h55555001, 32'h0, 32'h3FC0},
    '{24'h222222, 28'h1234FFF, 2'd2, 1'b0, 1'b1, 2'd1, 3'd1, 32'h66666000, 32'h0, 32'h3FC0},
    '{24'h333333, 28'h0F0F0AA, 2'd2, 1'b1, 1'b0, 2'd2, 3'd3, 32'h77777003, 32'h0, 32'h3FC0},
    '{24'h444444, 28'h0001000, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 32'h0,       32'h0, 32'h3FC0},
    '{24'h555555, 28'h8765432, 2'd0, 1'b0, 1'b0, 2'd2, 3'd7, 32'h00F00183, 32'h0, 32'h3FC0},
    '{24'h666666, 28'h2468ACE, 2'd1, 1'b0, 1'b0, 2'd1, 3'd2, 32'h0BAD0001, 32'h2000, 32'h1FC0},
    '{24'h777777, 28'h1357BDF, 2'd0, 1'b1, 1'b1, 2'd1, 3'd4, 32'h0CAFE000, 32'h0, 32'h3FC0},
    '{24'h888888, 28'h0FEDCBA, 2'd1, 1'b0, 1'b0, 2'd2, 3'd0, 32'h0BEEF003, 32'h0, 32'h3FC0}
  };

  // rights per R6: bit0 read, bit1 write, bit2 exec
  function automatic logic [2:0] exp_rights(input logic key, input logic [1:0] pp, input logic nx);
    logic [2:0] r;
    case ({key, pp})
      3'b011:  r = 3'b001;
      3'b000, 3'b001, 3'b010: r = 3'b011;
      3'b100:  r = 3'b000;
      3'b110:  r = 3'b011;
      default: r = 3'b001;
    endcase
    if (nx == 1'b0) r = r | 3'b100;
    return r;
  endfunction

  function automatic logic [31:0] grp(input logic [23:0] id, input logic [15:0] pg,
                                      input logic second, input logic [31:0] mask);
    logic [23:0] h;
    h = id ^ {8'h00, pg};
    if (second) h = h ^ 24'hFFFFFF;
    return ({8'h00, h} * 32'd64) & mask;
  endfunction

  task automatic poke(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[13:2]] <= val;
  endtask

  task automatic do_walk(input vec_t v, output bit ok);
    int n;
    @(negedge clk);
    vsid = v.vsid; seg_off = v.ea; acc_kind = v.acc; prot_key = v.key;
    no_exec = v.nx; tbl_base = v.base; tbl_mask = v.mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ok = 0;
    n = 0;
    while (n < 200) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
      n++;
    end
    if (!ok) check("R12 walk timeout", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input vec_t v, input int k);
    logic [15:0] pg;
    logic [31:0] pri, sec, eoff, w0, w1m;
    logic [2:0]  raw, need, expp;
    bit          ehit, egrant, ok, wr_r, wr_c;
    int          rd0, wr0, erd;
    string       tag;
    tag = $sformatf("vec%0d", k);
    pg  = v.ea[27:12];
    pri = grp(v.vsid, pg, 1'b0, v.mask);
    sec = grp(v.vsid, pg, 1'b1, v.mask);
    for (int i = 0; i < 16; i++) begin
      poke(v.base + pri + 32'(i * 4), 32'h0);
      poke(v.base + sec + 32'(i * 4), 32'h0);
    end
    @(negedge clk);
    w0 = {1'b1, v.vsid, (v.place == 2'd2), pg[15:10]};
    eoff = ((v.place == 2'd2) ? sec : pri) + 32'(v.slot) * 32'd8;
    // decoys: wrong hash-select copy, invalid copy, wrong-identifier entry
    poke(v.base + pri + 32'(v.slot) * 8, w0 & ~32'h40 | 32'h40);
    if (v.place == 2'd2 && v.slot != 3'd0) poke(v.base + sec, w0 & ~32'h40);
    if (v.place == 2'd1 && v.slot != 3'd0) poke(v.base + pri, w0 & 32'h7FFFFFFF);
    if (v.place == 2'd0) poke(v.base + pri + 8, {1'b1, v.vsid + 24'd1, 1'b0, pg[15:10]});
    if (v.place != 2'd0) begin
      poke(v.base + eoff, w0);
      poke(v.base + eoff + 4, v.w1);
    end
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    do_walk(v, ok);
    ehit   = (v.place != 2'd0);
    raw    = exp_rights(v.key, v.w1[1:0], v.nx);
    need   = (v.acc == 2'd0) ? 3'b001 : (v.acc == 2'd1) ? 3'b010 : 3'b100;
    egrant = ehit && ((raw & need) != 3'b000);
    expp   = raw;
    if (egrant && !v.w1[7] && v.acc != 2'd1) expp = raw & 3'b101;
    if (!ehit) expp = 3'b000;
    wr_r   = egrant && !v.w1[8];
    wr_c   = egrant && !v.w1[7] && v.acc == 2'd1;
    erd    = (v.place == 2'd0) ? 16 : (v.place == 2'd1) ? int'(v.slot) + 2 : 8 + int'(v.slot) + 2;
    check({"R2 R3 hit ", tag}, {31'd0, hit}, {31'd0, ehit});
    check({"R7 granted ", tag}, {31'd0, granted}, {31'd0, egrant});
    check({"R6 R9 prot ", tag}, {29'd0, prot}, {29'd0, expp});
    check({"R3 R4 R5 reads ", tag}, 32'(rd_cnt - rd0), 32'(erd));
    check({"R8 R9 writes ", tag}, 32'(wr_cnt - wr0), 32'(int'(wr_r) + int'(wr_c)));
    if (ehit) begin
      check({"R1 R10 entry_off ", tag}, entry_off, eoff);
      check({"R10 entry_w0 ", tag}, entry_w0, w0);
      check({"R10 entry_w1 ", tag}, entry_w1, v.w1);
      check({"R10 real_addr ", tag}, real_addr, {v.w1[31:12], v.ea[11:0]});
      w1m = v.w1;
      if (wr_r) w1m[8] = 1'b1;
      if (wr_c) w1m[7] = 1'b1;
      check({"R8 R9 R11 memory word1 ", tag}, mem[(v.base + eoff + 4) >> 2], w1m);
    end
    @(negedge clk);
    check({"R12 done pulse ", tag}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset done", {31'd0, done}, 32'd0);
    check("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
    check("R12 reset hit", {31'd0, hit}, 32'd0);
    check("R12 reset prot", {29'd0, prot}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
    // R12: results held after completion until next start
    begin
      vec_t v;
      logic [31:0] keep_w1, keep_ra;
      v = VECS[0];
      run_vec(v, 100);
      keep_w1 = entry_w1; keep_ra = real_addr;
      repeat (5) @(negedge clk);
      check("R12 hold hit", {31'd0, hit}, 32'd1);
      check("R12 hold entry_w1", entry_w1, keep_w1);
      check("R12 hold real_addr", real_addr, keep_ra);
      check("R12 idle busy", {31'd0, busy}, 32'd0);
      // second walk on the now-referenced entry: no R byte write (R8)
      begin
        int w0c;
        w0c = wr_cnt;
        do_walk(v, ok);
        check("R8 no rewrite when referenced set", 32'(wr_cnt - w0c), 32'd0);
        check("R9 load keeps write cleared", {29'd0, prot}, 32'd5);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule